// File: doc/BRIEF.md
# Skewed Clock Divider Bank

This block produces the output clocks of one bank of a multi-output clock buffer. It is driven by a fast timebase whose clock edge is one time unit (tU). An undivided output period lasts `TICK_N` ticks. Each bank divides that period by a ratio picked from a ternary select. It moves the resulting square wave earlier or later in whole tU steps, and it can invert chosen outputs. The bank can also stop its outputs without glitches, or put them in high impedance.

A parameter sets the bank kind. A near bank has a symmetric skew range of ±4 tU. A far bank has a wider range of ±6 to ±8 tU, and two of its rows copy the skew chosen by a neighbouring near bank. A feedback bank uses a single ternary phase input and drives only two outputs. Only one bank instance in a system is built with the inversion feature. All inputs are synchronous to the tick clock.

Top module: `skew_div_bank`

## Requirements
- R1: Every ternary input is 2 bits wide: 2'b00 = LOW, 2'b01 = MID, 2'b10 = HIGH, and 2'b11 behaves as MID. `div_sel[3:2]` is the high digit and `div_sel[1:0]` the low digit. The row index is 3×high + low, and rows 0 to 8 give ratios 1, 2, 3, 4, 5, 6, 8, 10, 12. The output period is TICK_N×ratio ticks with a 50 % duty cycle.
- R2: A near bank (BANK_KIND 0) uses the same row index on `ph_sel`. Rows 0 to 8 give skews of −4 to +4 tU. An output with skew s is high in ticks where (r − s) mod P < P/2. Here r is the reference tick count in the current period and P is the period. A negative skew wraps modulo P.
- R3: A far bank (BANK_KIND 1) maps rows 0,1,2 to −8,−7,−6 tU and row 4 to 0. Rows 6,7,8 map to +6,+7,+8 tU. Row 3 takes the near-bank skew of `peer_ph_a`, and row 5 takes the near-bank skew of `peer_ph_b`.
- R4: A feedback bank (BANK_KIND 2) takes its skew from `ph_sel[1:0]` alone: LOW −4, MID 0, HIGH +4 tU. Lanes 0 and 1 are driven. Lanes 2 and 3 stay low with their enables off.
- R5: Divide, phase and peer selects are sampled during reset and at the last tick of each reference period. A change takes effect only from the next period.
- R6: When `bank_off` is 1 and `drive_mode` is HIGH, every enable of the bank is 0 one tick later. When `bank_off` is 0, every driven lane is enabled one tick later.
- R7: When `bank_off` is 1 and `drive_mode` is LOW, each lane stops at its resting level. A true lane rests at 0 and an inverted lane rests at 1. A lane stops at the first tick where its next level equals the resting level, so no pulse is shortened. On release, a lane resumes only at a tick where its next level is the resting level.
- R8: With the inversion feature (HAS_INVERT = 1), `inv_sel` sets the lane polarity; lanes 0,1,2,3 are A0, A1, B0, B1. LOW inverts lanes 1 and 3. HIGH inverts all four lanes. MID inverts none. Inversion is applied after divide and skew.
- R9: When `drive_mode` is MID (or 2'b11), `bank_off` has no effect and the lanes keep running and enabled.
- R10: While `rst` is high, every output and every enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, one edge per tU |
| rst | input | 1 | Synchronous active-high reset |
| div_sel | input | 4 | Divide select, two ternary digits |
| ph_sel | input | 4 | Phase select, two ternary digits |
| peer_ph_a | input | 4 | Phase select of the first neighbouring near bank |
| peer_ph_b | input | 4 | Phase select of the second neighbouring near bank |
| bank_off | input | 1 | Bank disable request |
| drive_mode | input | 2 | Ternary: LOW hold-off, HIGH high impedance, MID test |
| inv_sel | input | 2 | Ternary polarity select |
| clk_out | output | 4 | Lane clock levels |
| clk_oe | output | 4 | Lane output enables |

## Verification
A hold-off stop and a select reload at a period boundary can fall in the same tick. Inversion changes and hold-off releases can also coincide with a boundary. The bench provokes this by changing the divide and phase selects while the bank is held off. It also toggles the disable at intervals that are not multiples of the period. A reference model in the bench predicts every lane level and enable for every tick on three bank kinds at once. A scoreboard compares the model with the design tick by tick, so a stop taken on the wrong edge or a reload taken early shows up as a mismatch.

// File: rtl/bank_clk_pkg.sv
package bank_clk_pkg;

  typedef logic signed [4:0] skew_t;

  localparam int KIND_NEAR = 0;
  localparam int KIND_FAR  = 1;
  localparam int KIND_FB   = 2;

  // ternary digit: 00 low, 10 high, 01/11 mid
  function automatic int tri_idx(input logic [1:0] v);
    case (v)
      2'b00:   return 0;
      2'b10:   return 2;
      default: return 1;
    endcase
  endfunction

  function automatic int row_of(input logic [3:0] sel);
    return 3 * tri_idx(sel[3:2]) + tri_idx(sel[1:0]);
  endfunction

  function automatic logic [3:0] div_ratio(input logic [3:0] sel);
    case (row_of(sel))
      0: return 4'd1;
      1: return 4'd2;
      2: return 4'd3;
      3: return 4'd4;
      4: return 4'd5;
      5: return 4'd6;
      6: return 4'd8;
      7: return 4'd10;
      default: return 4'd12;
    endcase
  endfunction

  function automatic skew_t skew_near(input logic [3:0] sel);
    int s;
    s = row_of(sel) - 4;
    return skew_t'(s);
  endfunction

  function automatic skew_t skew_far(input logic [3:0] sel,
                                     input logic [3:0] pa,
                                     input logic [3:0] pb);
    case (row_of(sel))
      0: return -5'sd8;
      1: return -5'sd7;
      2: return -5'sd6;
      3: return skew_near(pa);
      4: return 5'sd0;
      5: return skew_near(pb);
      6: return 5'sd6;
      7: return 5'sd7;
      default: return 5'sd8;
    endcase
  endfunction

  function automatic skew_t skew_fb(input logic [1:0] d);
    case (tri_idx(d))
      0: return -5'sd4;
      2: return 5'sd4;
      default: return 5'sd0;
    endcase
  endfunction

endpackage

// File: rtl/bank_sel_decode.sv
module bank_sel_decode
  import bank_clk_pkg::*;
#(
  parameter int KIND = KIND_NEAR
) (
  input  logic [3:0] div_sel,
  input  logic [3:0] ph_sel,
  input  logic [3:0] peer_a,
  input  logic [3:0] peer_b,
  output logic [3:0] ratio,
  output skew_t      skew
);
  logic dec_unused;
  assign dec_unused = ^{peer_a, peer_b, ph_sel};

  assign ratio = div_ratio(div_sel);

  generate
    if (KIND == KIND_FAR) begin : g_far
      assign skew = skew_far(ph_sel, peer_a, peer_b);
    end else if (KIND == KIND_FB) begin : g_fb
      assign skew = skew_fb(ph_sel[1:0]);
    end else begin : g_near
      assign skew = skew_near(ph_sel);
    end
  endgenerate
endmodule

// File: rtl/bank_phase_gen.sv
module bank_phase_gen
  import bank_clk_pkg::*;
#(
  parameter int TICK_N = 4,
  parameter int CW     = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] ratio_in,
  input  skew_t      skew_in,
  output logic       wave_nxt
);
  logic [CW-1:0] r_cnt, cur_per, cur_off;
  logic [CW-1:0] per_in, off_in, pos;
  logic          at_end;

  // period in ticks and skew folded into [0, period)
  always_comb begin
    int p;
    int m;
    p = int'(ratio_in) * TICK_N;
    m = int'(skew_in);
    for (int k = 0; k < 8; k++) begin
      if (m < 0)       m = m + p;
      else if (m >= p) m = m - p;
    end
    per_in = CW'(p);
    off_in = CW'(m);
  end

  assign at_end = (r_cnt == cur_per - CW'(1));

  always_ff @(posedge clk) begin
    if (rst || at_end) begin
      r_cnt   <= '0;
      cur_per <= per_in;
      cur_off <= off_in;
    end else begin
      r_cnt   <= r_cnt + CW'(1);
    end
  end

  assign pos      = (r_cnt >= cur_off) ? (r_cnt - cur_off)
                                       : (r_cnt + cur_per - cur_off);
  assign wave_nxt = (pos < (cur_per >> 1));
endmodule

// File: rtl/bank_out_lane.sv
module bank_out_lane (
  input  logic clk,
  input  logic rst,
  input  logic wave_nxt,
  input  logic invert,
  input  logic hold_req,
  input  logic hiz_req,
  output logic q,
  output logic oe
);
  logic stopped, stop_n, lvl_n;

  assign lvl_n  = wave_nxt ^ invert;
  assign stop_n = hold_req ? (stopped | (lvl_n == invert))
                           : (stopped & (lvl_n != invert));

  always_ff @(posedge clk) begin
    if (rst) begin
      q       <= 1'b0;
      oe      <= 1'b0;
      stopped <= 1'b0;
    end else begin
      q       <= stop_n ? invert : lvl_n;
      oe      <= ~hiz_req;
      stopped <= stop_n;
    end
  end
endmodule

// File: rtl/skew_div_bank.sv
module skew_div_bank
  import bank_clk_pkg::*;
#(
  parameter int TICK_N     = 4,
  parameter int BANK_KIND  = KIND_NEAR,
  parameter bit HAS_INVERT = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] div_sel,
  input  logic [3:0] ph_sel,
  input  logic [3:0] peer_ph_a,
  input  logic [3:0] peer_ph_b,
  input  logic       bank_off,
  input  logic [1:0] drive_mode,
  input  logic [1:0] inv_sel,
  output logic [3:0] clk_out,
  output logic [3:0] clk_oe
);
  localparam int LANES = (BANK_KIND == KIND_FB) ? 2 : 4;
  localparam int CW    = $clog2(12 * TICK_N + 1);

  logic [3:0] ratio;
  skew_t      skew;
  logic       wave_nxt;
  logic       hold_req, hiz_req;
  logic [3:0] pol;
  logic       top_unused;

  assign top_unused = ^inv_sel;
  assign hold_req   = bank_off && (tri_idx(drive_mode) == 0);
  assign hiz_req    = bank_off && (tri_idx(drive_mode) == 2);

  bank_sel_decode #(.KIND(BANK_KIND)) u_dec (
    .div_sel (div_sel),
    .ph_sel  (ph_sel),
    .peer_a  (peer_ph_a),
    .peer_b  (peer_ph_b),
    .ratio   (ratio),
    .skew    (skew)
  );

  bank_phase_gen #(.TICK_N(TICK_N), .CW(CW)) u_phase (
    .clk      (clk),
    .rst      (rst),
    .ratio_in (ratio),
    .skew_in  (skew),
    .wave_nxt (wave_nxt)
  );

  generate
    if (HAS_INVERT) begin : g_inv
      always_comb begin
        case (tri_idx(inv_sel))
          0:       pol = 4'b1010;
          2:       pol = 4'b1111;
          default: pol = 4'b0000;
        endcase
      end
    end else begin : g_noinv
      assign pol = 4'b0000;
    end

    for (genvar i = 0; i < 4; i++) begin : g_lane
      if (i < LANES) begin : g_on
        bank_out_lane u_lane (
          .clk      (clk),
          .rst      (rst),
          .wave_nxt (wave_nxt),
          .invert   (pol[i]),
          .hold_req (hold_req),
          .hiz_req  (hiz_req),
          .q        (clk_out[i]),
          .oe       (clk_oe[i])
        );
      end else begin : g_off
        logic lane_unused;
        assign lane_unused = pol[i];
        assign clk_out[i]  = 1'b0;
        assign clk_oe[i]   = 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/bank_check.sv
module bank_check (
  input logic       clk,
  input logic       rst,
  input logic       bank_off,
  input logic [1:0] drive_mode,
  input logic [1:0] inv_sel,
  input logic [3:0] clk_out,
  input logic [3:0] clk_oe
);
  logic hold_req, hiz_req, test_mode, lane0_true;
  assign hold_req   = bank_off && (drive_mode == 2'b00);
  assign hiz_req    = bank_off && (drive_mode == 2'b10);
  assign test_mode  = drive_mode[0];
  assign lane0_true = (inv_sel != 2'b10);

  AST_HIZ_NEXT: assert property (@(posedge clk) disable iff (rst)
    hiz_req |=> (clk_oe[0] == 1'b0)); // R6

  AST_ENABLE_NEXT: assert property (@(posedge clk) disable iff (rst)
    !bank_off |=> clk_oe[0]); // R6

  AST_TEST_RUNS: assert property (@(posedge clk) disable iff (rst)
    test_mode |=> clk_oe[0]); // R9

  AST_PARK_STAYS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(hold_req) && $past(lane0_true) && clk_out[0] == 1'b0
     && hold_req && lane0_true) |=> (clk_out[0] == 1'b0)); // R7

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (clk_out == 4'b0 && clk_oe == 4'b0)); // R10
endmodule

bind skew_div_bank bank_check u_bank_check (
  .clk        (clk),
  .rst        (rst),
  .bank_off   (bank_off),
  .drive_mode (drive_mode),
  .inv_sel    (inv_sel),
  .clk_out    (clk_out),
  .clk_oe     (clk_oe)
);

// File: tb/test_skew_div_bank.sv
module test_skew_div_bank;
  localparam int N = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] div_sel = 4'b0000;
  logic [3:0] ph_sel = 4'b0101;
  logic [3:0] peer_ph_a = 4'b0101;
  logic [3:0] peer_ph_b = 4'b0101;
  logic       bank_off = 1'b0;
  logic [1:0] drive_mode = 2'b10;
  logic [1:0] inv_sel = 2'b01;
  logic [3:0] q0, oe0, q1, oe1, q2, oe2;

  int    checks = 0;
  int    failures = 0;
  bit    done = 1'b0;
  string cur_tag = "R10";

  logic [23:0] exp_q[$];
  string       tag_q[$];

  int       m_r[3], m_per[3], m_off[3];
  logic [3:0] m_st[3];

  always #4 clk = ~clk;

  skew_div_bank #(.TICK_N(N), .BANK_KIND(0), .HAS_INVERT(1'b0)) i_skew_div_bank_near (
    .clk(clk), .rst(rst), .div_sel(div_sel), .ph_sel(ph_sel),
    .peer_ph_a(peer_ph_a), .peer_ph_b(peer_ph_b), .bank_off(bank_off),
    .drive_mode(drive_mode), .inv_sel(inv_sel), .clk_out(q0), .clk_oe(oe0));

  skew_div_bank #(.TICK_N(N), .BANK_KIND(1), .HAS_INVERT(1'b1)) i_skew_div_bank (
    .clk(clk), .rst(rst), .div_sel(div_sel), .ph_sel(ph_sel),
    .peer_ph_a(peer_ph_a), .peer_ph_b(peer_ph_b), .bank_off(bank_off),
    .drive_mode(drive_mode), .inv_sel(inv_sel), .clk_out(q1), .clk_oe(oe1));

  skew_div_bank #(.TICK_N(N), .BANK_KIND(2), .HAS_INVERT(1'b0)) i_skew_div_bank_fb (
    .clk(clk), .rst(rst), .div_sel(div_sel), .ph_sel(ph_sel),
    .peer_ph_a(peer_ph_a), .peer_ph_b(peer_ph_b), .bank_off(bank_off),
    .drive_mode(drive_mode), .inv_sel(inv_sel), .clk_out(q2), .clk_oe(oe2));

  function automatic int tix(input logic [1:0] v);
    return (v == 2'b00) ? 0 : (v == 2'b10) ? 2 : 1;
  endfunction

  function automatic logic [1:0] enc(input int i);
    return (i == 0) ? 2'b00 : (i == 1) ? 2'b01 : 2'b10;
  endfunction

  function automatic int bdiv(input logic [3:0] s);
    int tab[9] = '{1, 2, 3, 4, 5, 6, 8, 10, 12};
    return tab[3 * tix(s[3:2]) + tix(s[1:0])];
  endfunction

  function automatic int bnear(input logic [3:0] s);
    return 3 * tix(s[3:2]) + tix(s[1:0]) - 4;
  endfunction

  function automatic int bskew(input int kind, input logic [3:0] s,
                               input logic [3:0] pa, input logic [3:0] pb);
    int far_tab[9] = '{-8, -7, -6, 0, 0, 0, 6, 7, 8};
    int row;
    row = 3 * tix(s[3:2]) + tix(s[1:0]);
    if (kind == 0) return bnear(s);
    if (kind == 2) return (tix(s[1:0]) - 1) * 4;
    if (row == 3) return bnear(pa);
    if (row == 5) return bnear(pb);
    return far_tab[row];
  endfunction

  function automatic int bmod(input int s, input int p);
    return ((s % p) + p) % p;
  endfunction

  function automatic logic [3:0] bpol(input logic [1:0] v);
    return (tix(v) == 0) ? 4'b1010 : (tix(v) == 2) ? 4'b1111 : 4'b0000;
  endfunction

  // reference model: predicts every lane after each edge, pushes to scoreboard
  always @(posedge clk) begin
    logic [23:0] e;
    e = '0;
    for (int k = 0; k < 3; k++) begin
      logic [3:0] qv, oev, pol;
      logic base, hold, hiz, n, sn;
      int pos, lanes;
      qv = '0; oev = '0;
      if (rst) begin
        m_r[k]   = 0;
        m_per[k] = bdiv(div_sel) * N;
        m_off[k] = bmod(bskew(k, ph_sel, peer_ph_a, peer_ph_b), m_per[k]);
        m_st[k]  = '0;
      end else begin
        pos   = bmod(m_r[k] - m_off[k], m_per[k]);
        base  = (pos < m_per[k] / 2);
        pol   = (k == 1) ? bpol(inv_sel) : 4'b0000;
        hold  = bank_off && (drive_mode == 2'b00);
        hiz   = bank_off && (drive_mode == 2'b10);
        lanes = (k == 2) ? 2 : 4;
        for (int i = 0; i < 4; i++) begin
          if (i < lanes) begin
            n  = base ^ pol[i];
            sn = hold ? (m_st[k][i] | (n == pol[i])) : (m_st[k][i] & (n != pol[i]));
            m_st[k][i] = sn;
            qv[i]  = sn ? pol[i] : n;
            oev[i] = ~hiz;
          end
        end
        if (m_r[k] == m_per[k] - 1) begin
          m_r[k]   = 0;
          m_per[k] = bdiv(div_sel) * N;
          m_off[k] = bmod(bskew(k, ph_sel, peer_ph_a, peer_ph_b), m_per[k]);
        end else begin
          m_r[k] = m_r[k] + 1;
        end
      end
      e[k*8 +: 8] = {qv, oev};
    end
    exp_q.push_back(e);
    tag_q.push_back(cur_tag);
  end

  // monitor: compares design against the model away from the active edge
  always @(negedge clk) begin
    logic [23:0] e, a;
    string t;
    if (!done && exp_q.size() > 0) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = {q2, oe2, q1, oe1, q0, oe0};
      for (int k = 0; k < 3; k++) begin
        checks++;
        if (a[k*8 +: 8] != e[k*8 +: 8]) begin
          failures++;
          $display("FAIL %s bank%0d t=%0t actual out/oe=%b/%b expected %b/%b", t, k, $time,
                   a[k*8+4 +: 4], a[k*8 +: 4], e[k*8+4 +: 4], e[k*8 +: 4]);
        end
      end
    end
  end

  task automatic check_val(input logic [3:0] act, input logic [3:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s direct check actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic run(input int n, input string tag);
    cur_tag = tag;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    run(4, "R10");
    check_val(oe1, 4'b0000, "R10");
    check_val(q1, 4'b0000, "R10");
    rst = 1'b0;
    run(12, "R10");

    // R1: every divide row, plus the 2'b11 digit
    for (int d = 0; d < 9; d++) begin
      div_sel = {enc(d / 3), enc(d % 3)};
      run(110, "R1");
    end
    div_sel = 4'b1111;
    run(60, "R1");
    div_sel = 4'b0110;

    // R2 and R3: every phase row on near and far banks
    for (int p = 0; p < 9; p++) begin
      ph_sel = {enc(p / 3), enc(p % 3)};
      run(80, "R2 R3");
    end
    // R3: follow rows with distinct neighbour skews
    peer_ph_a = 4'b1010; peer_ph_b = 4'b0000;
    ph_sel = 4'b0100; run(80, "R3");
    ph_sel = 4'b0110; run(80, "R3");
    peer_ph_b = 4'b0001; run(80, "R3");

    // R4: feedback select uses the low digit only
    ph_sel = 4'b1000; run(80, "R4");
    ph_sel = 4'b0010; run(80, "R4");
    ph_sel = 4'b0101; run(40, "R4");

    // R5: selects changed off the period boundary
    for (int j = 0; j < 24; j++) begin
      div_sel = {enc(j % 3), enc((j / 3) % 3)};
      ph_sel  = {enc((j + 1) % 3), enc((j + 2) % 3)};
      run(7, "R5");
    end
    div_sel = 4'b0100; ph_sel = 4'b0101;
    run(40, "R5");

    // R6: high impedance disable
    drive_mode = 2'b10;
    bank_off = 1'b1; run(2, "R6");
    check_val(oe1, 4'b0000, "R6");
    run(28, "R6");
    bank_off = 1'b0; run(2, "R6");
    check_val(oe1, 4'b1111, "R6");
    for (int j = 0; j < 10; j++) begin
      bank_off = ~bank_off;
      run(3, "R6");
    end
    bank_off = 1'b0;

    // R7: hold-off, with polarity variants and select changes while stopped
    drive_mode = 2'b00;
    for (int v = 0; v < 3; v++) begin
      inv_sel = enc(v);
      bank_off = 1'b1; run(60, "R7");
      bank_off = 1'b0; run(45, "R7");
    end
    bank_off = 1'b1;
    div_sel = 4'b0001; ph_sel = 4'b0000; run(50, "R7");
    div_sel = 4'b1000; run(50, "R7");
    for (int j = 0; j < 16; j++) begin
      bank_off = ~bank_off;
      run(5 + (j % 4), "R7");
    end
    bank_off = 1'b0; run(60, "R7");

    // R8: polarity select sweep, including 2'b11
    div_sel = 4'b0001; ph_sel = 4'b0100;
    for (int v = 0; v < 4; v++) begin
      inv_sel = 2'(v);
      run(50, "R8");
    end

    // R9: test mode ignores the disable
    bank_off = 1'b1;
    drive_mode = 2'b01; run(50, "R9");
    check_val(oe1, 4'b1111, "R9");
    drive_mode = 2'b11; run(50, "R9");
    check_val(oe0, 4'b1111, "R9");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired, actual running expected finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule